// File: doc/BRIEF.md
# DMA Host Register Port

This block is the 8-bit programming port through which a host configures a four-channel DMA controller. The host presents a 4-bit port offset together with a write or read strobe. The block holds the per-channel 16-bit base address and base count, the per-channel mode fields, the channel mask bits, the software request bits, the terminal-count flags and the command byte. It also decodes the command ports that clear the byte pointer, perform a master clear, clear every mask bit or write every mask bit.

All registers are 8 bits wide on the host side. Each 16-bit address or count is reached through a single port. A byte pointer flip-flop, shared by all those ports, selects whether an access hits the low byte or the high byte, and it flips after every access. The channel engines receive the base values, a one-cycle load pulse, the decoded mode fields and the masks. They return their current address and count, their terminal-count pulses and their hardware request levels. Reads of an address or count port return the engine's current value.

Top module: `dma_host_regs`

## Requirements
- R1: After reset all mask bits are 1, the command byte is 0x00, all base registers are 0, the status read returns 0x00 when no hardware request is active, and the byte pointer selects the low byte.
- R2: For channel n, a write to offset 2n loads the base address and a write to offset 2n+1 loads the base count. The byte pointer selects the low byte (pointer 0) or the high byte (pointer 1).
- R3: Every read or write of offsets 0x0 to 0x7 flips the one shared byte pointer. A read returns the selected byte of the channel's current value from the engine.
- R4: A write of any value to offset 0xC clears the byte pointer, so that the next access hits the low byte.
- R5: A write to offset 0xA selects the channel with data bits [1:0] and sets that channel's mask bit to data bit 2. The other mask bits are unchanged.
- R6: A write to offset 0xB selects the channel with bits [1:0] and stores, for that channel, the transfer type from bits [3:2] (01 for I/O to memory, 10 for memory to I/O), autoinit from bit 4, address decrement from bit 5 and the operating mode from bits [7:6] (01 for single, 11 for cascade).
- R7: A write to offset 0xE clears all mask bits. A write to offset 0xF loads all mask bits from data bits [3:0].
- R8: A read of offset 0x8 returns the terminal-count flags in bits [3:0] and the OR of the software and hardware request bits in bits [7:4]. The read clears the terminal-count flags. A terminal-count pulse in the same cycle as the read is kept.
- R9: A write to offset 0x9 selects the channel with bits [1:0] and sets (bit 2 = 1) or clears (bit 2 = 0) that channel's software request bit.
- R10: A write to offset 0x8 stores the data byte as the command byte.
- R11: A write to offset 0xD clears the byte pointer, the command byte, the terminal-count flags and the software request bits, and sets all mask bits. Base registers and mode fields keep their values.
- R12: A read of offset 0xD returns the temporary data input. Reads of offsets 0x9, 0xA, 0xB, 0xC, 0xE and 0xF return 0x00.
- R13: When the read and write strobes are high in the same cycle, only the write takes effect, so the byte pointer flips once.
- R14: A byte write to a channel's address or count port raises that channel's bit of the load output for exactly the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 4 | Port offset |
| wdata_i | input | 8 | Write data |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | 8 | Read data, combinational from offset and state |
| cur_addr_i | input | 64 | Current address of each channel, 16 bits per channel |
| cur_cnt_i | input | 64 | Current count of each channel, 16 bits per channel |
| tc_i | input | 4 | Terminal-count pulse per channel |
| hw_req_i | input | 4 | Hardware request level per channel |
| temp_i | input | 8 | Temporary data byte |
| base_addr_o | output | 64 | Base address per channel |
| base_cnt_o | output | 64 | Base count per channel |
| base_load_o | output | 4 | One-cycle pulse after a base byte write |
| mask_o | output | 4 | Mask bit per channel |
| sw_req_o | output | 4 | Software request bit per channel |
| cmd_o | output | 8 | Command byte |
| xfer_type_o | output | 8 | Transfer type, 2 bits per channel |
| auto_init_o | output | 4 | Autoinit flag per channel |
| addr_dec_o | output | 4 | Address decrement flag per channel |
| op_mode_o | output | 8 | Operating mode, 2 bits per channel |

## Verification
On every cycle the assertions check these behaviours: the pointer flips on each channel-port access and is cleared by its clear and master-clear ports, the mask-all and clear-all ports take effect on the next cycle, master clear leaves the defined control state, a status read keeps only the same-cycle terminal-count pulses, the load pulse is one-hot and follows a channel write, and write-only offsets read as zero. Only the bench scenarios can show the following: that the bytes land in the right half of the right channel's register across pointer clears, that a read and a write share one pointer, that the mode fields decode into the correct channel, that status merges software and hardware requests, and that master clear preserves the base and mode contents.

// File: rtl/dmah_pkg.sv
package dmah_pkg;
  localparam int DW = 8;
  localparam int AW = 4;
  localparam int MW = 6;

  localparam logic [AW-1:0] OFF_CMD     = 4'h8;
  localparam logic [AW-1:0] OFF_REQ     = 4'h9;
  localparam logic [AW-1:0] OFF_SMASK   = 4'hA;
  localparam logic [AW-1:0] OFF_MODE    = 4'hB;
  localparam logic [AW-1:0] OFF_CLRPTR  = 4'hC;
  localparam logic [AW-1:0] OFF_MCLR    = 4'hD;
  localparam logic [AW-1:0] OFF_UNMASK  = 4'hE;
  localparam logic [AW-1:0] OFF_MASKALL = 4'hF;

  typedef struct packed {
    logic chan_wr;
    logic chan_rd;
    logic cmd_we;
    logic req_we;
    logic smask_we;
    logic mode_we;
    logic clrptr_we;
    logic mclr_we;
    logic unmask_we;
    logic maskall_we;
    logic stat_re;
  } strb_t;
endpackage

// File: rtl/dmah_decode.sv
module dmah_decode
  import dmah_pkg::*;
#(
  parameter int NCH = 4,
  localparam int CH_W = $clog2(NCH)
) (
  input  logic [AW-1:0]   addr_i,
  input  logic            wr_i,
  input  logic            rd_i,
  output strb_t           strb_o,
  output logic            in_chan_o,
  output logic [CH_W-1:0] ch_o,
  output logic            is_cnt_o
);
  logic rd_ok;

  assign rd_ok     = rd_i & ~wr_i;  // write wins on a double strobe
  assign in_chan_o = (int'(addr_i) < 2 * NCH);
  assign ch_o      = addr_i[CH_W:1];
  assign is_cnt_o  = addr_i[0];

  always_comb begin
    strb_o         = '0;
    strb_o.chan_wr = wr_i & in_chan_o;
    strb_o.chan_rd = rd_ok & in_chan_o;
    if (wr_i && !in_chan_o) begin
      case (addr_i)
        OFF_CMD:     strb_o.cmd_we     = 1'b1;
        OFF_REQ:     strb_o.req_we     = 1'b1;
        OFF_SMASK:   strb_o.smask_we   = 1'b1;
        OFF_MODE:    strb_o.mode_we    = 1'b1;
        OFF_CLRPTR:  strb_o.clrptr_we  = 1'b1;
        OFF_MCLR:    strb_o.mclr_we    = 1'b1;
        OFF_UNMASK:  strb_o.unmask_we  = 1'b1;
        OFF_MASKALL: strb_o.maskall_we = 1'b1;
        default: ;
      endcase
    end
    if (rd_ok && addr_i == OFF_CMD) strb_o.stat_re = 1'b1;
  end
endmodule

// File: rtl/dmah_chan_regs.sv
module dmah_chan_regs
  import dmah_pkg::*;
#(
  parameter int NCH = 4,
  parameter int RW  = 16,
  localparam int CH_W = $clog2(NCH)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            chan_wr_i,
  input  logic            mode_we_i,
  input  logic [CH_W-1:0] ch_i,
  input  logic            is_cnt_i,
  input  logic            ptr_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [NCH*RW-1:0] base_addr_o,
  output logic [NCH*RW-1:0] base_cnt_o,
  output logic [NCH-1:0]    base_load_o,
  output logic [NCH*MW-1:0] mode_o
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [RW-1:0] addr_q, cnt_q;
    logic [MW-1:0] mode_q;
    logic          load_q;
    logic          hit, mhit;

    assign hit  = chan_wr_i && (ch_i == CH_W'(c));
    assign mhit = mode_we_i && (wdata_i[CH_W-1:0] == CH_W'(c));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        addr_q <= '0;
        cnt_q  <= '0;
        mode_q <= '0;
        load_q <= 1'b0;
      end else begin
        load_q <= hit;
        if (hit && !is_cnt_i) begin
          if (ptr_i) addr_q[RW-1:DW] <= wdata_i;
          else       addr_q[DW-1:0]  <= wdata_i;
        end
        if (hit && is_cnt_i) begin
          if (ptr_i) cnt_q[RW-1:DW] <= wdata_i;
          else       cnt_q[DW-1:0]  <= wdata_i;
        end
        if (mhit) mode_q <= wdata_i[DW-1:DW-MW];
      end
    end

    assign base_addr_o[c*RW +: RW] = addr_q;
    assign base_cnt_o[c*RW +: RW]  = cnt_q;
    assign base_load_o[c]          = load_q;
    assign mode_o[c*MW +: MW]      = mode_q;
  end
endmodule

// File: rtl/dmah_ctrl.sv
module dmah_ctrl
  import dmah_pkg::*;
#(
  parameter int NCH = 4,
  localparam int CH_W = $clog2(NCH)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  strb_t          strb_i,
  input  logic [DW-1:0]  wdata_i,
  input  logic [NCH-1:0] tc_i,
  output logic           ptr_o,
  output logic [NCH-1:0] mask_o,
  output logic [NCH-1:0] sw_req_o,
  output logic [NCH-1:0] tc_o,
  output logic [DW-1:0]  cmd_o
);
  logic           ptr_q;
  logic [NCH-1:0] mask_q, mask_d, req_q, req_d, tc_q, tc_d;
  logic [DW-1:0]  cmd_q;
  logic [CH_W-1:0] sel;

  assign sel = wdata_i[CH_W-1:0];

  always_comb begin
    mask_d = mask_q;
    if (strb_i.mclr_we)         mask_d = '1;
    else if (strb_i.unmask_we)  mask_d = '0;
    else if (strb_i.maskall_we) mask_d = wdata_i[NCH-1:0];
    else if (strb_i.smask_we)   mask_d[sel] = wdata_i[2];
  end

  always_comb begin
    req_d = req_q;
    if (strb_i.mclr_we)     req_d = '0;
    else if (strb_i.req_we) req_d[sel] = wdata_i[2];
  end

  always_comb begin
    if (strb_i.mclr_we) tc_d = '0;
    else                tc_d = (tc_q & ~{NCH{strb_i.stat_re}}) | tc_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q  <= 1'b0;
      mask_q <= '1;
      req_q  <= '0;
      tc_q   <= '0;
      cmd_q  <= '0;
    end else begin
      if (strb_i.mclr_we || strb_i.clrptr_we)     ptr_q <= 1'b0;
      else if (strb_i.chan_wr || strb_i.chan_rd) ptr_q <= ~ptr_q;
      mask_q <= mask_d;
      req_q  <= req_d;
      tc_q   <= tc_d;
      if (strb_i.mclr_we)     cmd_q <= '0;
      else if (strb_i.cmd_we) cmd_q <= wdata_i;
    end
  end

  assign ptr_o    = ptr_q;
  assign mask_o   = mask_q;
  assign sw_req_o = req_q;
  assign tc_o     = tc_q;
  assign cmd_o    = cmd_q;
endmodule

// File: rtl/dma_host_regs.sv
module dma_host_regs
  import dmah_pkg::*;
#(
  parameter int NCH = 4,
  parameter int RW  = 16,
  localparam int CH_W = $clog2(NCH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [AW-1:0]     addr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic              wr_i,
  input  logic              rd_i,
  output logic [DW-1:0]     rdata_o,
  input  logic [NCH*RW-1:0] cur_addr_i,
  input  logic [NCH*RW-1:0] cur_cnt_i,
  input  logic [NCH-1:0]    tc_i,
  input  logic [NCH-1:0]    hw_req_i,
  input  logic [DW-1:0]     temp_i,
  output logic [NCH*RW-1:0] base_addr_o,
  output logic [NCH*RW-1:0] base_cnt_o,
  output logic [NCH-1:0]    base_load_o,
  output logic [NCH-1:0]    mask_o,
  output logic [NCH-1:0]    sw_req_o,
  output logic [DW-1:0]     cmd_o,
  output logic [2*NCH-1:0]  xfer_type_o,
  output logic [NCH-1:0]    auto_init_o,
  output logic [NCH-1:0]    addr_dec_o,
  output logic [2*NCH-1:0]  op_mode_o
);
  strb_t            strb;
  logic             in_chan, is_cnt, ptr_q;
  logic [CH_W-1:0]  ch;
  logic [NCH-1:0]   tc_q;
  logic [NCH*MW-1:0] mode;
  logic [RW-1:0]    cur;
  logic [2*NCH-1:0] stat;

  dmah_decode #(.NCH(NCH)) u_dec (
    .addr_i(addr_i), .wr_i(wr_i), .rd_i(rd_i),
    .strb_o(strb), .in_chan_o(in_chan), .ch_o(ch), .is_cnt_o(is_cnt)
  );

  dmah_ctrl #(.NCH(NCH)) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .strb_i(strb), .wdata_i(wdata_i),
    .tc_i(tc_i), .ptr_o(ptr_q), .mask_o(mask_o), .sw_req_o(sw_req_o),
    .tc_o(tc_q), .cmd_o(cmd_o)
  );

  dmah_chan_regs #(.NCH(NCH), .RW(RW)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .chan_wr_i(strb.chan_wr),
    .mode_we_i(strb.mode_we), .ch_i(ch), .is_cnt_i(is_cnt), .ptr_i(ptr_q),
    .wdata_i(wdata_i), .base_addr_o(base_addr_o), .base_cnt_o(base_cnt_o),
    .base_load_o(base_load_o), .mode_o(mode)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_mode
    assign xfer_type_o[2*c +: 2] = mode[c*MW +: 2];
    assign auto_init_o[c]        = mode[c*MW + 2];
    assign addr_dec_o[c]         = mode[c*MW + 3];
    assign op_mode_o[2*c +: 2]   = mode[c*MW + 4 +: 2];
  end

  assign stat = {sw_req_o | hw_req_i, tc_q};
  assign cur  = is_cnt ? cur_cnt_i[ch*RW +: RW] : cur_addr_i[ch*RW +: RW];

  always_comb begin
    rdata_o = '0;
    if (in_chan) begin
      rdata_o = ptr_q ? cur[RW-1:DW] : cur[DW-1:0];
    end else begin
      case (addr_i)
        OFF_CMD:  rdata_o = DW'(stat);
        OFF_MCLR: rdata_o = temp_i;
        default:  rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/dma_host_regs_chk.sv
module dma_host_regs_chk
  import dmah_pkg::*;
#(
  parameter int NCH = 4
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic [AW-1:0]  addr_i,
  input logic [DW-1:0]  wdata_i,
  input logic           wr_i,
  input logic           rd_i,
  input logic [DW-1:0]  rdata_o,
  input logic [NCH-1:0] tc_i,
  input logic [NCH-1:0] mask_o,
  input logic [NCH-1:0] sw_req_o,
  input logic [NCH-1:0] base_load_o,
  input logic [DW-1:0]  cmd_o,
  input logic           ptr_q,
  input logic [NCH-1:0] tc_q
);
  logic chan_acc;
  assign chan_acc = (wr_i || rd_i) && (int'(addr_i) < 2 * NCH);

  p_ptr_toggle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chan_acc |=> ptr_q != $past(ptr_q));

  p_ptr_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == OFF_CLRPTR) |=> !ptr_q);

  p_unmask_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == OFF_UNMASK) |=> mask_o == '0);

  p_mask_all_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == OFF_MASKALL) |=> mask_o == $past(wdata_i[NCH-1:0]));

  p_tc_rdclr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !wr_i && addr_i == OFF_CMD) |=> tc_q == $past(tc_i));

  p_cmd_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == OFF_CMD) |=> cmd_o == $past(wdata_i));

  p_mclr_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == OFF_MCLR) |=>
      (mask_o == '1 && cmd_o == '0 && sw_req_o == '0 && tc_q == '0 && !ptr_q));

  p_load_onehot_r14: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(base_load_o));

  p_load_cause_r14: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (base_load_o != '0) |-> $past(wr_i && (int'(addr_i) < 2 * NCH)));

  always @(posedge clk_i) begin
    if (rst_ni && (addr_i == OFF_REQ || addr_i == OFF_SMASK || addr_i == OFF_MODE ||
                   addr_i == OFF_CLRPTR || addr_i == OFF_UNMASK || addr_i == OFF_MASKALL))
      p_wo_zero_r12: assert (rdata_o == '0);
  end
endmodule

bind dma_host_regs dma_host_regs_chk #(.NCH(NCH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wdata_i(wdata_i),
  .wr_i(wr_i), .rd_i(rd_i), .rdata_o(rdata_o), .tc_i(tc_i),
  .mask_o(mask_o), .sw_req_o(sw_req_o), .base_load_o(base_load_o),
  .cmd_o(cmd_o), .ptr_q(ptr_q), .tc_q(tc_q)
);

// File: tb/sim_dma_host_regs.sv
module sim_dma_host_regs;
  localparam int NCH = 4;
  localparam int RW  = 16;
  localparam int NV  = 16;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic wr = 1'b0, rd = 1'b0;
  logic [7:0] rdata;
  logic [NCH*RW-1:0] base_addr, base_cnt;
  logic [NCH-1:0] tc = '0, hw_req = '0, base_load, mask, sw_req, auto_init, addr_dec;
  logic [7:0] temp = '0, cmd;
  logic [2*NCH-1:0] xfer_type, op_mode;
  int checks = 0, fails = 0;
  logic [7:0] rv;

  always #4 clk = ~clk;

  dma_host_regs u0 (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .wdata_i(wdata), .wr_i(wr),
    .rd_i(rd), .rdata_o(rdata), .cur_addr_i(base_addr), .cur_cnt_i(base_cnt),
    .tc_i(tc), .hw_req_i(hw_req), .temp_i(temp), .base_addr_o(base_addr),
    .base_cnt_o(base_cnt), .base_load_o(base_load), .mask_o(mask),
    .sw_req_o(sw_req), .cmd_o(cmd), .xfer_type_o(xfer_type),
    .auto_init_o(auto_init), .addr_dec_o(addr_dec), .op_mode_o(op_mode)
  );

  // {is_read, offset, data or expected byte}
  localparam logic [12:0] VEC [NV] = '{
    {1'b0, 4'h0, 8'h34}, {1'b0, 4'h0, 8'h12}, {1'b0, 4'h1, 8'hFF}, {1'b0, 4'h1, 8'h00},
    {1'b0, 4'h6, 8'hCD}, {1'b0, 4'h6, 8'hAB}, {1'b0, 4'h5, 8'h78}, {1'b0, 4'h5, 8'h56},
    {1'b1, 4'h0, 8'h34}, {1'b1, 4'h0, 8'h12}, {1'b1, 4'h5, 8'h78}, {1'b1, 4'h5, 8'h56},
    {1'b1, 4'h6, 8'hCD}, {1'b1, 4'h6, 8'hAB}, {1'b1, 4'h1, 8'hFF}, {1'b1, 4'h1, 8'h00}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic do_rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1'b1;
    #2 d = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic do_both(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1; rd = 1'b1;
    @(negedge clk); wr = 1'b0; rd = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 mask", 32'(mask), 32'hF);
    chk("R1 cmd", 32'(cmd), 32'h0);
    chk("R1 base", 32'(base_addr[31:0] | base_cnt[31:0]), 32'h0);
    do_rd(4'h8, rv); chk("R1 status", 32'(rv), 32'h0);

    // R2/R3 table: writes then readbacks through the shared pointer
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][12]) begin
        do_rd(VEC[i][11:8], rv);
        chk("R3 readback", 32'(rv), 32'(VEC[i][7:0]));
      end else begin
        do_wr(VEC[i][11:8], VEC[i][7:0]);
      end
    end
    chk("R2 ch0 addr", 32'(base_addr[0*RW +: RW]), 32'h1234);
    chk("R2 ch0 cnt", 32'(base_cnt[0*RW +: RW]), 32'h00FF);
    chk("R2 ch3 addr", 32'(base_addr[3*RW +: RW]), 32'hABCD);
    chk("R2 ch2 cnt", 32'(base_cnt[2*RW +: RW]), 32'h5678);
    chk("R2 ch1 addr untouched", 32'(base_addr[1*RW +: RW]), 32'h0);

    // R4 pointer clear
    do_wr(4'h0, 8'h11);
    do_wr(4'hC, 8'hA7);
    do_wr(4'h0, 8'h22);
    chk("R4 low again", 32'(base_addr[0 +: RW]), 32'h1222);
    do_wr(4'hC, 8'h00);

    // R3 a read advances the pointer used by a write
    do_rd(4'h0, rv); chk("R3 read low", 32'(rv), 32'h22);
    do_wr(4'h0, 8'h99);
    chk("R3 shared ptr", 32'(base_addr[0 +: RW]), 32'h9922);

    // R13 double strobe flips once
    do_both(4'h0, 8'h44);
    do_wr(4'h0, 8'h55);
    chk("R13 write wins", 32'(base_addr[0 +: RW]), 32'h5544);

    // R14 load pulse
    do_wr(4'h3, 8'h10);
    chk("R14 pulse", 32'(base_load), 32'h2);
    @(negedge clk);
    chk("R14 one cycle", 32'(base_load), 32'h0);
    chk("R2 ch1 cnt low", 32'(base_cnt[1*RW +: RW]), 32'h0010);
    do_wr(4'hC, 8'h00);

    // R5 single mask
    do_wr(4'hA, 8'h00);
    chk("R5 clear ch0", 32'(mask), 32'hE);
    do_wr(4'hA, 8'h01); do_wr(4'hA, 8'h02); do_wr(4'hA, 8'h03);
    do_wr(4'hA, 8'h06);
    chk("R5 set ch2", 32'(mask), 32'h4);

    // R7 clear-all and write-all masks
    do_wr(4'hF, 8'h0A);
    chk("R7 mask all", 32'(mask), 32'hA);
    do_wr(4'hE, 8'h00);
    chk("R7 unmask", 32'(mask), 32'h0);
    do_wr(4'hF, 8'hF5);
    chk("R7 mask all low nibble", 32'(mask), 32'h5);

    // R6 mode fields
    do_wr(4'hB, 8'h56);
    chk("R6 ch2 xfer", 32'(xfer_type[5:4]), 32'h1);
    chk("R6 ch2 auto", 32'(auto_init[2]), 32'h1);
    chk("R6 ch2 op", 32'(op_mode[5:4]), 32'h1);
    do_wr(4'hB, 8'hEB);
    chk("R6 ch3 fields", 32'({op_mode[7:6], addr_dec[3], auto_init[3], xfer_type[7:6]}), 32'h3A);
    chk("R6 ch2 kept", 32'(xfer_type[5:4]), 32'h1);

    // R10 command
    do_wr(4'h8, 8'hA5);
    chk("R10 cmd", 32'(cmd), 32'hA5);

    // R9 software request, R8 status
    do_wr(4'h9, 8'h05);
    chk("R9 set ch1", 32'(sw_req), 32'h2);
    hw_req = 4'b1000;
    do_rd(4'h8, rv); chk("R8 req merge", 32'(rv), 32'hA0);
    @(negedge clk); tc = 4'b0101;
    @(negedge clk); tc = 4'b0000;
    do_rd(4'h8, rv); chk("R8 tc flags", 32'(rv), 32'hA5);
    do_rd(4'h8, rv); chk("R8 read clears", 32'(rv), 32'hA0);
    @(negedge clk); addr = 4'h8; rd = 1'b1; tc = 4'b0010;
    #2 rv = rdata;
    @(negedge clk); rd = 1'b0; tc = 4'b0000;
    chk("R8 same-cycle read", 32'(rv), 32'hA0);
    do_rd(4'h8, rv); chk("R8 same-cycle kept", 32'(rv), 32'hA2);
    do_wr(4'h9, 8'h01);
    chk("R9 clear ch1", 32'(sw_req), 32'h0);
    do_wr(4'h9, 8'h07);

    // R11 master clear
    hw_req = 4'b0000;
    @(negedge clk); tc = 4'b1000;
    @(negedge clk); tc = 4'b0000;
    do_wr(4'h0, 8'h77);
    do_wr(4'hD, 8'h00);
    chk("R11 mask", 32'(mask), 32'hF);
    chk("R11 cmd", 32'(cmd), 32'h0);
    chk("R11 req", 32'(sw_req), 32'h0);
    do_rd(4'h8, rv); chk("R11 status", 32'(rv), 32'h0);
    do_wr(4'h0, 8'h88);
    chk("R11 ptr low", 32'(base_addr[0 +: RW]), 32'h5588);
    chk("R11 base kept", 32'(base_addr[3*RW +: RW]), 32'hABCD);
    chk("R11 mode kept", 32'(op_mode[7:6]), 32'h3);

    // R12 temp and write-only reads
    temp = 8'h3C;
    do_rd(4'hD, rv); chk("R12 temp", 32'(rv), 32'h3C);
    do_rd(4'hA, rv); chk("R12 write-only", 32'(rv), 32'h0);
    do_rd(4'hF, rv); chk("R12 write-only F", 32'(rv), 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule